// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces a continuous stream of complete Ethernet MAC frames for a traffic source. Each frame is built from a set of settings: destination address, source address, length/type value, a separate payload size for type frames, a payload seed and an inter-frame gap. The block sends the frame in order: the preamble and start delimiter, both addresses, the length/type field, an incrementing payload, zero padding where needed, and the frame check sequence. The CRC is computed on the fly as words leave the block.

The output is a 64-bit word stream with valid/ready handshaking. Byte lane 0 (bits 7:0) carries the earliest byte of each word. Start-of-frame marks the first word and end-of-frame marks the last. On the last word, a 3-bit field gives the number of valid bytes minus one. While ready is low, the block holds the current word unchanged, and it advances exactly one word on each cycle where valid and ready are both high. After the final word is accepted, the output stays idle for the configured number of cycles before the next frame begins. Settings are sampled only at a frame boundary.

Top module: `efg_frame_gen`

## Requirements
- R1: While reset is asserted, `out_valid` is low. After reset, frames start without further stimulus.
- R2: Every frame begins with one word holding seven 0x55 bytes in lanes 0..6 and 0xD5 in lane 7. That word alone carries `out_sof`.
- R3: Bytes 8..13 of the frame are the destination address and bytes 14..19 the source address, each sent from bits 47:40 down to bits 7:0. Bit 0 of the first destination byte (setting bit 40) is sent exactly as configured.
- R4: The length/type field is sent at bytes 20..21, high byte first. A value below 1536 gives the payload size directly. A value of 1536 or more gives the payload size through `cfg_type_len`. In both cases the payload size is limited to 1500.
- R5: Payload byte i carries (`cfg_seed` + i) mod 256.
- R6: Zero bytes follow the payload until the destination-through-padding span is at least 60 bytes, so destination-through-FCS is at least 64 and at most 1518 bytes. The frame carries no other extra bytes.
- R7: Four FCS bytes follow the padding. They hold the complement of the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones), least significant byte first, computed over bytes from the destination address through the padding.
- R8: `out_eof` marks the last word, where `out_last_bytes` equals the number of valid bytes minus one and the unused lanes are zero. On every other word `out_last_bytes` is 7.
- R9: While `out_valid` is high and `out_ready` is low, the word and all side-band outputs stay unchanged. No byte is lost or repeated.
- R10: Between acceptance of a last word and the next start-of-frame word, `out_valid` is low for exactly the gap captured for the next frame.
- R11: All settings, including the gap, are captured when the previous frame's last word is accepted (or, after reset, on the first cycle). Changes at any other time do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst | input | 48 | Destination address |
| cfg_src | input | 48 | Source address |
| cfg_lentype | input | 16 | Length/type field value |
| cfg_type_len | input | 11 | Payload size used when the field is a type |
| cfg_seed | input | 8 | First payload byte value |
| cfg_gap | input | 16 | Idle cycles before the frame |
| out_data | output | 64 | Frame bytes, lane 0 earliest |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Sink accepts the word |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| out_last_bytes | output | 3 | Valid bytes minus one on the last word |

## Verification
Two functions can land in the same word: the last payload or pad bytes, and the FCS bytes that depend on them. The FCS can also split across that word and the end-of-frame word. The bench provokes this by sweeping payload sizes 46..69, which places the FCS at every one of the eight lane offsets, while a pseudo-random ready pattern stalls the stream, including on the shared word. Each received frame is compared byte for byte, region by region, against a frame the bench builds itself with a bit-serial CRC, and the end-of-frame lane count is checked against the computed length.

// File: rtl/efg_pkg.sv
package efg_pkg;
  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [31:0] CRC_REFL  = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;
  localparam int          TYPE_FLOOR = 1536;
  localparam int          BODY_MIN   = 60;   // destination through pad
  localparam int          HDR_LEN    = 14;   // addresses plus length/type
  localparam int          LEAD_LEN   = 8;    // preamble plus delimiter

  typedef enum logic [1:0] {ST_START, ST_GAP, ST_SEND} efg_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/efg_frame_setup.sv
module efg_frame_setup
  import efg_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1500,
  parameter int PW = 11,
  parameter int LB = 3,
  parameter int GW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [47:0]       cfg_dst,
  input  logic [47:0]       cfg_src,
  input  logic [15:0]       cfg_lentype,
  input  logic [10:0]       cfg_type_len,
  input  logic [7:0]        cfg_seed,
  output logic [47:0]       dst_q,
  output logic [47:0]       src_q,
  output logic [15:0]       lt_q,
  output logic [7:0]        seed_q,
  output logic [PW-1:0]     pay_end_q,
  output logic [PW-1:0]     body_end_q,
  output logic [PW-LB-1:0]  last_word_q,
  output logic [LB-1:0]     last_bytes_q
);
  localparam logic [PW-1:0] P_PAY  = PW'(LEAD_LEN + HDR_LEN);
  localparam logic [PW-1:0] P_BMIN = PW'(LEAD_LEN + BODY_MIN);
  localparam logic [PW-1:0] P_MAXP = PW'(MAX_PAYLOAD);

  logic [15:0]   raw_len;
  logic [PW-1:0] plen_c, pay_end_c, body_end_c, tail_c;

  always_comb begin
    raw_len = (cfg_lentype < 16'(TYPE_FLOOR)) ? cfg_lentype : {5'h0, cfg_type_len};
    plen_c  = (raw_len > 16'(MAX_PAYLOAD)) ? P_MAXP : PW'(raw_len);
    pay_end_c  = P_PAY + plen_c;
    body_end_c = (pay_end_c < P_BMIN) ? P_BMIN : pay_end_c;
    tail_c     = body_end_c + PW'(3);   // position of the final FCS byte
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q <= '0; src_q <= '0; lt_q <= '0; seed_q <= '0;
      pay_end_q <= P_PAY; body_end_q <= P_BMIN;
      last_word_q <= '0; last_bytes_q <= '0;
    end else if (capture) begin
      dst_q <= cfg_dst;
      src_q <= cfg_src;
      lt_q <= cfg_lentype;
      seed_q <= cfg_seed;
      pay_end_q <= pay_end_c;
      body_end_q <= body_end_c;
      last_word_q <= tail_c[PW-1:LB];
      last_bytes_q <= tail_c[LB-1:0];
    end
  end

  AST_PAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capture) |-> (body_end_q >= P_BMIN) && (body_end_q <= PW'(LEAD_LEN + HDR_LEN + MAX_PAYLOAD))); // R6
endmodule

// File: rtl/efg_lane_map.sv
module efg_lane_map
  import efg_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PW = 11,
  parameter int LB = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-LB-1:0]     word_idx,
  input  logic [47:0]          dst_q,
  input  logic [47:0]          src_q,
  input  logic [15:0]          lt_q,
  input  logic [7:0]           seed_q,
  input  logic [PW-1:0]        pay_end_q,
  input  logic [PW-1:0]        body_end_q,
  output logic [LANES*8-1:0]   base_bytes,
  output logic [LANES-1:0]     body_mask,
  output logic [LANES-1:0]     fcs_mask,
  output logic [LANES*2-1:0]   fcs_sel
);
  localparam logic [PW-1:0] P_SFD = PW'(LEAD_LEN - 1);
  localparam logic [PW-1:0] P_DA  = PW'(LEAD_LEN);
  localparam logic [PW-1:0] P_SA  = PW'(LEAD_LEN + 6);
  localparam logic [PW-1:0] P_LT  = PW'(LEAD_LEN + 12);
  localparam logic [PW-1:0] P_PAY = PW'(LEAD_LEN + HDR_LEN);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PW-1:0] pos, rel;
    logic [7:0]    b;
    logic          in_body, in_fcs;
    always_comb begin
      pos = {word_idx, LB'(g)};
      rel = pos - body_end_q;
      in_body = (pos >= P_DA) && (pos < body_end_q);
      in_fcs  = (pos >= body_end_q) && (rel < PW'(4));
      if (pos < P_SFD)                b = PRE_BYTE;
      else if (pos == P_SFD)          b = SFD_BYTE;
      else if (pos < P_SA)            b = 8'(dst_q >> (8 * (5 - int'(pos - P_DA))));
      else if (pos < P_LT)            b = 8'(src_q >> (8 * (5 - int'(pos - P_SA))));
      else if (pos == P_LT)           b = lt_q[15:8];
      else if (pos == P_LT + PW'(1))  b = lt_q[7:0];
      else if (pos < pay_end_q)       b = seed_q + 8'(pos - P_PAY);
      else                            b = 8'h00;   // pad, FCS slot or unused lane
    end
    assign base_bytes[g*8 +: 8] = b;
    assign body_mask[g] = in_body;
    assign fcs_mask[g]  = in_fcs;
    assign fcs_sel[g*2 +: 2] = rel[1:0];
  end

  AST_FCS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fcs_mask) <= 4) && ((body_mask & fcs_mask) == '0)); // R7
endmodule

// File: rtl/efg_fcs_calc.sv
module efg_fcs_calc
  import efg_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               advance,
  input  logic [LANES*8-1:0] bytes,
  input  logic [LANES-1:0]   mask,
  output logic [31:0]        crc_next
);
  logic [31:0] crc_q;

  always_comb begin
    crc_next = crc_q;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) crc_next = crc_step(crc_next, bytes[i*8 +: 8]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC_PRESET;
    else if (init)    crc_q <= CRC_PRESET;
    else if (advance) crc_q <= crc_next;
  end

  AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (crc_next == crc_q)); // R7
endmodule

// File: rtl/efg_frame_gen.sv
module efg_frame_gen
  import efg_pkg::*;
#(
  parameter int MAX_PAYLOAD = 1500,
  parameter int GW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_dst,
  input  logic [47:0] cfg_src,
  input  logic [15:0] cfg_lentype,
  input  logic [10:0] cfg_type_len,
  input  logic [7:0]  cfg_seed,
  input  logic [15:0] cfg_gap,
  output logic [63:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_sof,
  output logic        out_eof,
  output logic [2:0]  out_last_bytes
);
  localparam int LANES = 8;
  localparam int LB = $clog2(LANES);
  localparam int MAX_BYTES = LEAD_LEN + HDR_LEN + MAX_PAYLOAD + 4;
  localparam int PW = $clog2(MAX_BYTES + LANES);
  localparam int WW = PW - LB;

  efg_state_t        state;
  logic [WW-1:0]     word_q;
  logic [GW-1:0]     gap_q;
  logic              beat, capture;

  logic [47:0]       dst_q, src_q;
  logic [15:0]       lt_q;
  logic [7:0]        seed_q;
  logic [PW-1:0]     pay_end_q, body_end_q;
  logic [WW-1:0]     last_word_q;
  logic [LB-1:0]     last_bytes_q;

  logic [LANES*8-1:0] base_bytes;
  logic [LANES-1:0]   body_mask, fcs_mask;
  logic [LANES*2-1:0] fcs_sel;
  logic [31:0]        crc_next, fcs_val;

  assign out_valid = (state == ST_SEND);
  assign beat      = out_valid && out_ready;
  assign out_sof   = out_valid && (word_q == '0);
  assign out_eof   = out_valid && (word_q == last_word_q);
  assign capture   = (state == ST_START) || (beat && out_eof);
  assign out_last_bytes = out_eof ? last_bytes_q : LB'(LANES - 1);

  efg_frame_setup #(.MAX_PAYLOAD(MAX_PAYLOAD), .PW(PW), .LB(LB), .GW(GW)) u_setup (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .cfg_dst(cfg_dst), .cfg_src(cfg_src), .cfg_lentype(cfg_lentype),
    .cfg_type_len(cfg_type_len), .cfg_seed(cfg_seed),
    .dst_q(dst_q), .src_q(src_q), .lt_q(lt_q), .seed_q(seed_q),
    .pay_end_q(pay_end_q), .body_end_q(body_end_q),
    .last_word_q(last_word_q), .last_bytes_q(last_bytes_q)
  );

  efg_lane_map #(.LANES(LANES), .PW(PW), .LB(LB)) u_lanes (
    .clk(clk), .rst_n(rst_n), .word_idx(word_q),
    .dst_q(dst_q), .src_q(src_q), .lt_q(lt_q), .seed_q(seed_q),
    .pay_end_q(pay_end_q), .body_end_q(body_end_q),
    .base_bytes(base_bytes), .body_mask(body_mask),
    .fcs_mask(fcs_mask), .fcs_sel(fcs_sel)
  );

  efg_fcs_calc #(.LANES(LANES)) u_fcs (
    .clk(clk), .rst_n(rst_n), .init(capture), .advance(beat),
    .bytes(base_bytes), .mask(body_mask), .crc_next(crc_next)
  );

  assign fcs_val = ~crc_next;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign out_data[g*8 +: 8] = fcs_mask[g] ? 8'(fcs_val >> (8 * int'(fcs_sel[g*2 +: 2])))
                                            : base_bytes[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_START;
      word_q <= '0;
      gap_q  <= '0;
    end else if (capture) begin
      word_q <= '0;
      gap_q  <= GW'(cfg_gap);
      state  <= (cfg_gap == '0) ? ST_SEND : ST_GAP;
    end else if (state == ST_GAP) begin
      gap_q <= gap_q - GW'(1);
      if (gap_q == GW'(1)) state <= ST_SEND;
    end else if (beat) begin
      word_q <= word_q + WW'(1);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_eof)
                                   && $stable(out_sof) && $stable(out_last_bytes)); // R9
  AST_SOF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !out_eof); // R2
  AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && out_eof) |=> !out_eof); // R8
endmodule

// File: tb/sim_efg_frame_gen.sv
module sim_efg_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] cfg_dst, cfg_src;
  logic [15:0] cfg_lentype, cfg_gap;
  logic [10:0] cfg_type_len;
  logic [7:0]  cfg_seed;
  logic [63:0] out_data;
  logic        out_valid, out_ready, out_sof, out_eof;
  logic [2:0]  out_last_bytes;

  always #4 clk = ~clk;

  efg_frame_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dst(cfg_dst), .cfg_src(cfg_src),
    .cfg_lentype(cfg_lentype), .cfg_type_len(cfg_type_len), .cfg_seed(cfg_seed),
    .cfg_gap(cfg_gap), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_eof(out_eof),
    .out_last_bytes(out_last_bytes)
  );

  localparam int NF = 83;
  int total = 0, bad = 0;
  logic [7:0] rx [0:2047];
  logic [7:0] ex [0:2047];
  int rx_n, ex_n, pay_end, body_end;

  function automatic logic [15:0] f_lt(int k);
    if (k < 70) return 16'(k);
    if (k < 80) return 16'h0800 + 16'(k);
    if (k == 80) return 16'd1500;
    if (k == 81) return 16'd1520;
    return 16'h86DD;
  endfunction
  function automatic logic [10:0] f_tl(int k);
    if (k >= 70 && k < 80) return 11'((k - 70) * 7);
    if (k == 82) return 11'd2000;
    return 11'd0;
  endfunction
  function automatic logic [47:0] f_da(int k);
    return {7'h2A ^ 7'(k), 1'(k), 40'h1122334455 ^ 40'(k * 97)};
  endfunction
  function automatic logic [47:0] f_sa(int k);
    return 48'hA0B1C2D3E4F5 + 48'(k * 4099);
  endfunction
  function automatic logic [15:0] f_gap(int k);
    return 16'(k % 5);
  endfunction

  task automatic apply(int k);
    cfg_dst = f_da(k); cfg_src = f_sa(k); cfg_lentype = f_lt(k);
    cfg_type_len = f_tl(k); cfg_seed = 8'(k * 37); cfg_gap = f_gap(k);
  endtask

  task automatic chk(bit ok, string req, longint act, longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic build(int k);
    int plen;
    logic [31:0] c;
    logic [15:0] lt;
    lt = f_lt(k);
    plen = (lt < 16'd1536) ? int'(lt) : int'(f_tl(k));
    if (plen > 1500) plen = 1500;
    pay_end = 22 + plen;
    body_end = (pay_end < 68) ? 68 : pay_end;
    for (int i = 0; i < 7; i++) ex[i] = 8'h55;
    ex[7] = 8'hD5;
    for (int i = 0; i < 6; i++) begin
      ex[8 + i]  = f_da(k)[47 - 8*i -: 8];
      ex[14 + i] = f_sa(k)[47 - 8*i -: 8];
    end
    ex[20] = lt[15:8]; ex[21] = lt[7:0];
    for (int i = 22; i < body_end; i++)
      ex[i] = (i < pay_end) ? 8'(k * 37) + 8'(i - 22) : 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 8; i < body_end; i++) begin
      c = c ^ {24'h0, ex[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) ex[body_end + i] = c[8*i +: 8];
    ex_n = body_end + 4;
  endtask

  task automatic region(int lo, int hi, string req);
    int miss = 0, fa = 0, fe = 0;
    for (int i = lo; i < hi; i++) begin
      if (i >= rx_n || rx[i] !== ex[i]) begin
        if (miss == 0) begin fa = (i < rx_n) ? int'(rx[i]) : -1; fe = int'(ex[i]); end
        miss++;
      end
    end
    chk(miss == 0, req, fa, fe);
  endtask

  initial begin
    int frame, idle, cyc;
    bit waiting, prev_hold, last7_ok;
    logic [63:0] prev_data;
    logic [15:0] lfsr;
    rst_n = 1'b0; out_ready = 1'b0; apply(0);
    rx_n = 0; frame = 0; idle = 0; cyc = 0; waiting = 1; prev_hold = 0;
    last7_ok = 1; lfsr = 16'hACE1; prev_data = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R1 valid low in reset", out_valid, 0);
    end
    rst_n = 1'b1;
    while (frame < NF && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (prev_hold) chk(out_valid && out_data == prev_data, "R9 held word", out_data, prev_data);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      if (!out_valid && waiting) idle++;
      if (out_valid && waiting) begin
        waiting = 0;
        if (frame > 0) chk(idle == int'(f_gap(frame)), "R10 gap", idle, f_gap(frame));
        // R11: next settings applied while this frame is in flight
        if (frame + 1 < NF) apply(frame + 1);
      end
      if (out_valid && out_ready) begin
        int nb;
        if (rx_n == 0) chk(out_sof, "R2 sof on first word", out_sof, 1);
        else if (out_sof) chk(0, "R2 stray sof", rx_n, 0);
        nb = out_eof ? int'(out_last_bytes) + 1 : 8;
        if (!out_eof && out_last_bytes != 3'd7) last7_ok = 0;
        for (int i = 0; i < nb; i++) rx[rx_n + i] = out_data[8*i +: 8];
        rx_n += nb;
        if (out_eof) begin
          build(frame);
          if (nb < 8) chk((out_data >> (8*nb)) == 64'h0, "R8 unused lanes zero", out_data, 0);
          chk(nb == ex_n - 8*((ex_n - 1) / 8), "R8 last byte count", nb, ex_n - 8*((ex_n - 1)/8));
          chk(last7_ok, "R8 full-word count", 0, 7);
          chk(rx_n == ex_n, "R6 frame length", rx_n, ex_n);
          region(0, 8, "R2 lead bytes");
          region(8, 20, "R3 addresses");
          region(20, 22, "R4 length/type");
          region(22, pay_end, "R5 payload");
          region(pay_end, body_end, "R6 pad");
          region(body_end, ex_n, "R7 fcs");
          frame++; rx_n = 0; waiting = 1; idle = 0; last7_ok = 1;
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
    if (frame < NF) chk(0, "watchdog expired", frame, NF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule